// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block keeps hardware activity counts for a processor subsystem. It holds one free-running cycle counter and four event counters, each 32 bits wide. Software programs it through a small register port with an address, write data, a write strobe, combinational read data and a flag marking the access as privileged. Four single-bit event lines feed the event counters, and one interrupt line reports overflows that software has chosen to see.

A control register carries a master run bit, two one-shot clear strobes (one for the event counters, one for the cycle counter) and a divide-by-64 option for the cycle counter. Per-counter enable and interrupt-enable masks are changed only by set and clear writes, so software never needs a read-modify-write. Overflow flags are sticky until software clears them. A user-access bit decides whether unprivileged code may touch the registers at all.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter, the control register, both masks, the overflow flags and the user-access bit read 0, and `irq` is low.
- R2: A counter advances only while control bit 0 and its own enable bit are both 1. An event counter adds one for each clock in which its event input is high. The cycle counter adds one per clock when the divider is off.
- R3: All masks use bit 31 for the cycle counter and bits 3:0 for event counters 0 to 3, with all other bits reading 0. A write to address 1 sets every enable written as 1 and leaves the rest alone. A write to address 2 clears every enable written as 1. Both addresses read back the current enable mask.
- R4: Writing control (address 0) with bit 1 set zeroes all event counters, and writing it with bit 2 set zeroes the cycle counter, each in that single cycle. The clear bits read back 0. Control reads return bit 0 (run) and bit 3 (divide).
- R5: With control bit 3 set, the cycle counter advances once per 64 enabled clocks. The 64-clock phase restarts from zero whenever the cycle counter is cleared through control bit 2.
- R6: A counter at all-ones that advances wraps to zero, sets its overflow flag and keeps counting.
- R7: Address 3 reads the overflow flags. A write to it clears each flag written as 1. An overflow in the same cycle as a clear of that flag leaves the flag set.
- R8: Address 4 sets interrupt enables and address 5 clears them (bits written as 1); both read the mask. `irq` is high exactly when some counter has both its overflow flag and its interrupt enable set.
- R9: A write to address 7 loads the cycle counter, and a write to addresses 8 to 11 loads event counter 0 to 3. A load that coincides with an increment takes the written value.
- R10: Address 6 bit 0 is the user-access bit, writable only by privileged accesses. While it is 0, unprivileged writes change nothing and unprivileged reads return 0. While it is 1, unprivileged accesses behave as privileged ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| priv | input | 1 | High for a privileged access |
| rd_data | output | 32 | Read data for `addr`, combinational |
| event_in | input | 4 | Event lines for event counters 0 to 3 |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Two functions collide here: a register write and a counter update landing on the same clock edge. The bench holds an event input high during the very cycle in which software either clears that counter's overflow flag while the counter wraps, or loads the counter. The flag must survive the clear, and the counter must hold exactly the loaded value. The prescaler phase is judged the same way, by counting the clock edges between the enabling write and the disabling write and checking that the 64th enabled edge, and no earlier one, moves the cycle counter.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int CYC_BIT = 31;   // mask bit that stands for the cycle counter

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_OVF   = 4'd3;
  localparam logic [ADDR_W-1:0] A_IESET = 4'd4;
  localparam logic [ADDR_W-1:0] A_IECLR = 4'd5;
  localparam logic [ADDR_W-1:0] A_USER  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CYC   = 4'd7;
  localparam logic [ADDR_W-1:0] A_EVT0  = 4'd8;

  // control register bit positions
  localparam int C_RUN  = 0;
  localparam int C_ECLR = 1;
  localparam int C_CCLR = 2;
  localparam int C_DIV  = 3;
endpackage

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  // priority: clear, then load, then increment
  always_comb begin
    step  = inc_i && !clr_i && !ld_i;
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (ld_i)  cnt_d = ld_val_i;
    else if (inc_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = step && (cnt_q == '1);

  // R2: without any request the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_i && !clr_i) |=> $stable(cnt_q));

  // R6: all-ones plus one gives zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && !clr_i && cnt_q == '1) |=> (cnt_q == '0));

  // R9: a load lands exactly, even against an increment
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !clr_i) |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/pmu_prescaler.sv
`timescale 1ns/1ps
module pmu_prescaler #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic div_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] phase_q, phase_d;
  logic                phase_en;

  always_comb begin
    phase_en = clr_i || (run_i && div_i);
    phase_d  = clr_i ? '0 : phase_q + DIV_LOG2'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign tick_o = run_i && (!div_i || phase_q == '1);

  // R5: a divided tick closes the phase, so the next one is a full period away
  p_phase_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i && !clr_i) |=> (phase_q == '0));

  // R5: clearing the cycle counter restarts the phase
  p_phase_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_en,
  input  logic               priv,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] event_in,
  output logic               irq
);
  localparam int MSK_W   = NUM_EVT + 1;
  localparam int CYC_IDX = NUM_EVT;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // ---------------- access gating and decode ----------------
  logic             user_en_q, user_en_d, user_we;
  logic             acc_ok, wr_ok;
  logic             hit_ctrl, hit_enset, hit_enclr, hit_ovf, hit_ieset, hit_ieclr, hit_cyc;
  logic [MSK_W-1:0] wmask;

  assign acc_ok    = priv || user_en_q;
  assign wr_ok     = wr_en && acc_ok;
  assign hit_ctrl  = wr_ok && (addr == A_CTRL);
  assign hit_enset = wr_ok && (addr == A_ENSET);
  assign hit_enclr = wr_ok && (addr == A_ENCLR);
  assign hit_ovf   = wr_ok && (addr == A_OVF);
  assign hit_ieset = wr_ok && (addr == A_IESET);
  assign hit_ieclr = wr_ok && (addr == A_IECLR);
  assign hit_cyc   = wr_ok && (addr == A_CYC);
  assign user_we   = wr_en && priv && (addr == A_USER);
  assign wmask     = {wr_data[CYC_BIT], wr_data[NUM_EVT-1:0]};

  // ---------------- control and mask state ----------------
  logic             run_q, run_d, div_q, div_d;
  logic             evt_clr, cyc_clr;
  logic [MSK_W-1:0] cen_q, cen_d, ien_q, ien_d, ovf_q, ovf_d, ovf_pulse;
  logic             cen_we, ien_we;

  always_comb begin
    run_d     = wr_data[C_RUN];
    div_d     = wr_data[C_DIV];
    evt_clr   = hit_ctrl && wr_data[C_ECLR];
    cyc_clr   = hit_ctrl && wr_data[C_CCLR];
    user_en_d = wr_data[0];
    cen_we    = hit_enset || hit_enclr;
    cen_d     = hit_enset ? (cen_q | wmask) : (cen_q & ~wmask);
    ien_we    = hit_ieset || hit_ieclr;
    ien_d     = hit_ieset ? (ien_q | wmask) : (ien_q & ~wmask);
    // a fresh overflow outranks a clear in the same cycle
    ovf_d     = (ovf_q & ~(hit_ovf ? wmask : '0)) | ovf_pulse;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q     <= 1'b0;
      div_q     <= 1'b0;
      user_en_q <= 1'b0;
      cen_q     <= '0;
      ien_q     <= '0;
      ovf_q     <= '0;
    end else begin
      if (hit_ctrl) begin
        run_q <= run_d;
        div_q <= div_d;
      end
      if (user_we) user_en_q <= user_en_d;
      if (cen_we)  cen_q     <= cen_d;
      if (ien_we)  ien_q     <= ien_d;
      ovf_q <= ovf_d;
    end
  end

  // ---------------- cycle counter with prescaler ----------------
  logic             cyc_run, cyc_tick;
  logic [CNT_W-1:0] cyc_cnt;

  assign cyc_run = run_q && cen_q[CYC_IDX];

  pmu_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (cyc_run),
    .div_i  (div_q),
    .clr_i  (cyc_clr),
    .tick_o (cyc_tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (cyc_clr),
    .ld_i     (hit_cyc),
    .ld_val_i (wr_data[CNT_W-1:0]),
    .inc_i    (cyc_tick),
    .cnt_o    (cyc_cnt),
    .ovf_o    (ovf_pulse[CYC_IDX])
  );

  // ---------------- event counters ----------------
  logic [CNT_W-1:0] evt_cnt [NUM_EVT];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic hit_ld, inc;
    assign hit_ld = wr_ok && (addr == A_EVT0 + ADDR_W'(g));
    assign inc    = run_q && cen_q[g] && event_in[g];
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .clr_i    (evt_clr),
      .ld_i     (hit_ld),
      .ld_val_i (wr_data[CNT_W-1:0]),
      .inc_i    (inc),
      .cnt_o    (evt_cnt[g]),
      .ovf_o    (ovf_pulse[g])
    );
  end

  // ---------------- read path and interrupt ----------------
  function automatic logic [DATA_W-1:0] spread(input logic [MSK_W-1:0] m);
    logic [DATA_W-1:0] r;
    r               = '0;
    r[CYC_BIT]      = m[CYC_IDX];
    r[NUM_EVT-1:0]  = m[NUM_EVT-1:0];
    return r;
  endfunction

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:           begin rd_mux[C_RUN] = run_q; rd_mux[C_DIV] = div_q; end
      A_ENSET, A_ENCLR: rd_mux = spread(cen_q);
      A_OVF:            rd_mux = spread(ovf_q);
      A_IESET, A_IECLR: rd_mux = spread(ien_q);
      A_USER:           rd_mux[0] = user_en_q;
      A_CYC:            rd_mux = DATA_W'(cyc_cnt);
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (addr == A_EVT0 + ADDR_W'(i)) rd_mux = DATA_W'(evt_cnt[i]);
      end
    endcase
  end

  assign rd_data = acc_ok ? rd_mux : '0;
  assign irq     = |(ovf_q & ien_q);

  // R10: blocked unprivileged writes leave the masks alone
  p_user_block_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !priv && !user_en_q) |=> ($stable(cen_q) && $stable(ien_q) && $stable(run_q)));

  // R4: the cycle clear strobe zeroes the cycle counter in one step
  p_cyc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    cyc_clr |=> (cyc_cnt == '0));

  // R7: a flag only drops after a clearing write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!hit_ovf) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R8: interrupt stays low while no enable is set
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic [31:0] wr_data;
  logic        wr_en;
  logic        priv;
  logic [31:0] rd_data;
  logic [3:0]  event_in;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  perf_mon_unit i_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .priv(priv), .rd_data(rd_data), .event_in(event_in), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd1, 32'h8000_0005, 4'd1, 32'h8000_0005, 8'd3},
    '{1'b1, 4'd1, 32'h0000_0002, 4'd1, 32'h8000_0007, 8'd3},
    '{1'b1, 4'd2, 32'h8000_0001, 4'd2, 32'h0000_0006, 8'd3},
    '{1'b1, 4'd4, 32'h8000_000F, 4'd4, 32'h8000_000F, 8'd8},
    '{1'b1, 4'd5, 32'h0000_000A, 4'd5, 32'h8000_0005, 8'd8},
    '{1'b1, 4'd7, 32'h1234_5678, 4'd7, 32'h1234_5678, 8'd9},
    '{1'b1, 4'd9, 32'hCAFE_F00D, 4'd9, 32'hCAFE_F00D, 8'd9},
    '{1'b1, 4'd0, 32'h0000_000F, 4'd0, 32'h0000_0009, 8'd4},
    '{1'b0, 4'd0, 32'h0,         4'd9, 32'h0000_0000, 8'd4},
    '{1'b0, 4'd0, 32'h0,         4'd7, 32'h0000_0000, 8'd4},
    '{1'b1, 4'd0, 32'h0000_0000, 4'd0, 32'h0000_0000, 8'd4},
    '{1'b1, 4'd5, 32'h8000_000F, 4'd5, 32'h0000_0000, 8'd8},
    '{1'b1, 4'd2, 32'h8000_000F, 4'd1, 32'h0000_0000, 8'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, commit at the next rising edge, return at the falling edge after
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; priv = p;
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, input logic p, output logic [31:0] v);
    @(negedge clk);
    addr = a; priv = p;
    #1 v = rd_data;
    priv = 1'b1;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, 1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_ev0();
    @(negedge clk); event_in = 4'b0001;
    @(negedge clk); event_in = 4'b0000;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; addr = '0; wr_data = '0; wr_en = 1'b0; priv = 1'b1; event_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rdchk("R1 ctrl", 4'd0, 32'h0);
    rdchk("R1 enables", 4'd1, 32'h0);
    rdchk("R1 flags", 4'd3, 32'h0);
    rdchk("R1 irq enables", 4'd4, 32'h0);
    rdchk("R1 user", 4'd6, 32'h0);
    rdchk("R1 cycle", 4'd7, 32'h0);
    rdchk("R1 event0", 4'd8, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // register semantics table (R3, R4, R8, R9)
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata, 1'b1);
      rd(VECS[i].raddr, 1'b1, v);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R10: user access gating
    wr(4'd1, 32'h1, 1'b0);
    rdchk("R10 blocked write", 4'd1, 32'h0);
    rd(4'd6, 1'b0, v);
    chk("R10 blocked read", v, 32'h0);
    wr(4'd6, 32'h1, 1'b1);
    wr(4'd1, 32'h1, 1'b0);
    rd(4'd1, 1'b0, v);
    chk("R10 user write allowed", v, 32'h1);
    wr(4'd6, 32'h0, 1'b0);
    rdchk("R10 user cannot drop access bit", 4'd6, 32'h1);
    wr(4'd6, 32'h0, 1'b1);
    wr(4'd2, 32'h1, 1'b1);

    // R2: event counting under run and per-counter enable
    wr(4'd1, 32'h3, 1'b1);
    wr(4'd0, 32'h3, 1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      event_in = {1'b0, 1'b1, (k < 3), 1'b1};
    end
    @(negedge clk); event_in = '0;
    rdchk("R2 event0 count", 4'd8, 32'd5);
    rdchk("R2 event1 count", 4'd9, 32'd3);
    rdchk("R2 event2 disabled", 4'd10, 32'd0);
    wr(4'd0, 32'h0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); event_in = 4'b0001;
    end
    @(negedge clk); event_in = '0;
    rdchk("R2 run bit off holds", 4'd8, 32'd5);
    wr(4'd2, 32'h3, 1'b1);

    // R2 cycle counter: 10 idle cycles plus the two write edges
    wr(4'd1, 32'h8000_0000, 1'b1);
    wr(4'd0, 32'h5, 1'b1);
    repeat (10) @(negedge clk);
    wr(4'd0, 32'h0, 1'b1);
    rdchk("R2 cycle count", 4'd7, 32'd12);
    rdchk("R4 cycle clear spares events", 4'd8, 32'd5);

    // R5: divide by 64
    wr(4'd0, 32'hD, 1'b1);
    repeat (61) @(negedge clk);
    wr(4'd0, 32'h0, 1'b1);               // 63 enabled edges
    rdchk("R5 no tick before 64", 4'd7, 32'd0);
    wr(4'd0, 32'h9, 1'b1);               // next edge is the 64th
    rdchk("R5 tick on 64th", 4'd7, 32'd1);
    repeat (30) @(negedge clk);
    rdchk("R5 spacing", 4'd7, 32'd1);
    wr(4'd0, 32'hD, 1'b1);               // clear restarts the phase
    repeat (61) @(negedge clk);
    wr(4'd0, 32'h0, 1'b1);
    rdchk("R5 phase restart", 4'd7, 32'd0);
    wr(4'd2, 32'h8000_0000, 1'b1);

    // R6 / R7 / R8: overflow, flags, interrupt
    wr(4'd1, 32'h1, 1'b1);
    wr(4'd4, 32'h1, 1'b1);
    wr(4'd8, 32'hFFFF_FFFF, 1'b1);
    wr(4'd0, 32'h1, 1'b1);
    pulse_ev0();
    rdchk("R6 wrap to zero", 4'd8, 32'h0);
    rdchk("R6 flag set", 4'd3, 32'h1);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    pulse_ev0();
    rdchk("R6 keeps counting", 4'd8, 32'h1);
    wr(4'd5, 32'h1, 1'b1);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    rdchk("R7 flag stays", 4'd3, 32'h1);
    wr(4'd3, 32'h1, 1'b1);
    rdchk("R7 flag cleared", 4'd3, 32'h0);

    // R7: overflow and clear in the same cycle
    wr(4'd8, 32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    event_in = 4'b0001; addr = 4'd3; wr_data = 32'h1; wr_en = 1'b1; priv = 1'b1;
    @(negedge clk);
    event_in = '0; wr_en = 1'b0;
    rdchk("R7 set beats clear", 4'd3, 32'h1);
    rdchk("R7 counter wrapped", 4'd8, 32'h0);

    // R9: load beats increment
    @(negedge clk);
    event_in = 4'b0001; addr = 4'd8; wr_data = 32'd100; wr_en = 1'b1; priv = 1'b1;
    @(negedge clk);
    event_in = '0; wr_en = 1'b0;
    rdchk("R9 load beats increment", 4'd8, 32'd100);

    // R6: cycle counter overflow lands in bit 31
    wr(4'd3, 32'h8000_000F, 1'b1);
    wr(4'd1, 32'h8000_0000, 1'b1);
    wr(4'd7, 32'hFFFF_FFFE, 1'b1);
    repeat (4) @(negedge clk);
    rdchk("R6 cycle flag bit31", 4'd3, 32'h8000_0000);
    chk("R8 no irq without enable", {31'b0, irq}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule